// File: doc/BRIEF.md
# Asymmetric Decode Slot Allocator

This block sits between an instruction pre-decode stage and a micro-op queue. Two hardware threads each present a window of up to four pre-decoded instructions in program order. Each instruction carries the number of fused micro-ops it expands to. On each turn the block serves one thread. It places the head instruction in the wide slot, which may produce one to four micro-ops. It then fills the remaining narrow slots with following single-micro-op instructions, and registers a packed group of at most four micro-op lanes for the queue below.

Each instruction longer than four micro-ops is handed to a sequencer model. The sequencer streams that instruction four micro-ops per cycle until it is done. During that time neither thread's window is consumed. The block reports, per thread, how many instructions it took in a cycle, and the upstream stage advances its window by that amount at the clock edge. When the queue below is not ready, the registered group is held and nothing is taken.

Each output lane carries the length of the instruction it came from and its micro-op index within that instruction, so the queue can see where instructions start and end.

Top module: `dsa_alloc_top`

## Requirements
- R1: After reset, out_valid is 0, both take counts are 0, and thread A (out_thr = 0) has the first turn.
- R2: The head instruction of the served window, if it has 1 to 4 micro-ops, occupies lanes 0 to n-1 with lane length n and indices 0 to n-1, and is taken (take count at least 1).
- R3: Only instructions with exactly one micro-op fill the narrow slots. Their number is limited to 4 minus the head's micro-op count, so a group never holds more than 4 micro-ops.
- R4: Instructions are taken strictly in order. Filling stops at the first following instruction whose length is not 1, and that instruction waits for a later turn where it becomes the head.
- R5: A head instruction longer than 4 micro-ops is taken alone. Its micro-ops appear with out_from_seq = 1, four per cycle, with indices counting up from 0, and the final cycle carries the remainder.
- R6: While the sequencer is still streaming after its first cycle, both take counts stay 0 even when windows hold instructions.
- R7: Turns alternate between thread A and thread B on every cycle the output advances, and at most one thread has a non-zero take count. A sequencer run keeps the turn until its last cycle, and the other thread is served next.
- R8: While out_valid is 1 and out_ready is 0, the output group, thread and lane fields stay unchanged and both take counts are 0.
- R9: A turn whose window is empty takes nothing, produces no group (out_valid 0 next cycle) and still passes the turn on.
- R10: A valid group has its lanes packed from lane 0 upward (valid bits form a run starting at bit 0). Every micro-op of every instruction leaves exactly once, in per-thread program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_cnt_a | input | CW | Number of valid instructions in thread A window (0..LANES) |
| in_len_a | input | LANES*UW | Thread A micro-op counts; entry i in bits [i*UW +: UW], entry 0 is oldest, each 1 or more |
| in_cnt_b | input | CW | Number of valid instructions in thread B window |
| in_len_b | input | LANES*UW | Thread B micro-op counts, same layout |
| take_a | output | CW | Instructions of thread A consumed at the next edge |
| take_b | output | CW | Instructions of thread B consumed at the next edge |
| out_ready | input | 1 | Micro-op queue can accept the current group |
| out_valid | output | 1 | Output group holds at least one micro-op |
| out_thr | output | 1 | Thread of the group (0 = A, 1 = B) |
| out_lane_vld | output | LANES | Per-lane valid |
| out_lane_len | output | LANES*UW | Per-lane length of the source instruction |
| out_lane_idx | output | LANES*UW | Per-lane micro-op index within its instruction |
| out_from_seq | output | 1 | Group was produced by the sequencer |

## Verification
Directed windows come first. One is four single-micro-op instructions, which fills every narrow slot. One has a three-micro-op head followed by singles, which shows that the narrow slots shrink. One has a double behind a single, which shows that filling stops in order. A ten-micro-op instruction then exercises the sequencer: it produces 4, 4 and 2 micro-ops, and the other thread's window sits untouched during the run. An empty window shows that a turn passes without any group. Random streams of mixed lengths, random window fill levels and random back-pressure are then compared against bench-side greedy take counts and a per-thread micro-op scoreboard. The scoreboard reveals any lost, duplicated or reordered micro-op, and any micro-op wrongly routed to or away from the sequencer.

// File: rtl/dsa_pkg.sv
// Shared types for the decode slot allocator.
package dsa_pkg;
    // Which hardware thread owns the current decode turn.
    typedef enum logic {
        THR_A = 1'b0,
        THR_B = 1'b1
    } thr_e;
endpackage

// File: rtl/dsa_thread_turn.sv
// Turn keeper: holds which thread owns the decoders and muxes that thread's
// instruction window. Assumes the turn flips only on cycles the output stage
// advances and hold_turn is low.
module dsa_thread_turn
    import dsa_pkg::*;
#(
    parameter int LANES = 4,
    parameter int UW    = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                hold_turn,
    input  logic [CW-1:0]       cnt_a,
    input  logic [LANES*UW-1:0] len_a,
    input  logic [CW-1:0]       cnt_b,
    input  logic [LANES*UW-1:0] len_b,
    output thr_e                cur,
    output logic [CW-1:0]       win_cnt,
    output logic [LANES*UW-1:0] win_len
);
    thr_e cur_q;

    // Flip the turn on each advancing cycle not claimed by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cur_q <= THR_A;
        else if (adv && !hold_turn) cur_q <= (cur_q == THR_A) ? THR_B : THR_A;
    end

    // Present the window of the thread that owns this turn.
    always_comb begin
        cur     = cur_q;
        win_cnt = (cur_q == THR_A) ? cnt_a : cnt_b;
        win_len = (cur_q == THR_A) ? len_a : len_b;
    end
endmodule

// File: rtl/dsa_slot_alloc.sv
// Slot allocator: places the head instruction in the wide slot (1..LANES
// micro-ops) and fills the freed lanes with following single micro-op
// instructions in order. Flags a head longer than LANES for the sequencer.
// Assumes every valid window entry has a length of at least one.
module dsa_slot_alloc #(
    parameter int LANES = 4,
    parameter int UW    = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic [CW-1:0]       win_cnt,
    input  logic [LANES*UW-1:0] win_len,
    output logic [CW-1:0]       take,
    output logic                long_go,
    output logic [LANES-1:0]    lane_vld,
    output logic [LANES*UW-1:0] lane_len,
    output logic [LANES*UW-1:0] lane_idx
);
    logic [UW-1:0] head;
    logic          stop;
    int            fill;

    // Greedy in-order fill: wide slot first, then singles until one fails.
    always_comb begin
        take     = '0;
        long_go  = 1'b0;
        lane_vld = '0;
        lane_len = '0;
        lane_idx = '0;
        stop     = 1'b0;
        fill     = 0;
        head     = win_len[UW-1:0];
        if (win_cnt != '0) begin
            take = CW'(1);
            if (head > UW'(LANES)) begin
                long_go = 1'b1;
            end else begin
                for (int j = 0; j < LANES; j++) begin
                    if (UW'(j) < head) begin
                        lane_vld[j]          = 1'b1;
                        lane_len[j*UW +: UW] = head;
                        lane_idx[j*UW +: UW] = UW'(j);
                    end
                end
                fill = int'(head);
                for (int i = 1; i < LANES; i++) begin
                    if (!stop && (CW'(i) < win_cnt) &&
                        (win_len[i*UW +: UW] == UW'(1)) && (fill < LANES)) begin
                        lane_vld[fill]          = 1'b1;
                        lane_len[fill*UW +: UW] = UW'(1);
                        lane_idx[fill*UW +: UW] = '0;
                        fill                    = fill + 1;
                        take                    = take + CW'(1);
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dsa_ucode_seq.sv
// Sequencer model: streams the micro-ops of an instruction longer than LANES,
// LANES per cycle. The first chunk leaves in the same cycle the instruction is
// taken; busy then covers the remaining chunks. Assumes start only when idle.
module dsa_ucode_seq #(
    parameter int LANES = 4,
    parameter int UW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                start,
    input  logic [UW-1:0]       start_len,
    output logic                busy,
    output logic                last,
    output logic [LANES-1:0]    lane_vld,
    output logic [LANES*UW-1:0] lane_len,
    output logic [LANES*UW-1:0] lane_idx
);
    logic          busy_q;
    logic [UW-1:0] len_q, pos_q, src_len, src_pos, remain;

    // Produce this cycle's chunk from either the running or the new instruction.
    always_comb begin
        src_len  = busy_q ? len_q : start_len;
        src_pos  = busy_q ? pos_q : '0;
        remain   = src_len - src_pos;
        busy     = busy_q;
        last     = busy_q && (remain <= UW'(LANES));
        lane_vld = '0;
        lane_len = '0;
        lane_idx = '0;
        if (busy_q || start) begin
            for (int j = 0; j < LANES; j++) begin
                if (UW'(j) < remain) begin
                    lane_vld[j]          = 1'b1;
                    lane_len[j*UW +: UW] = src_len;
                    lane_idx[j*UW +: UW] = src_pos + UW'(j);
                end
            end
        end
    end

    // Track progress through the long instruction on each advancing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            len_q  <= '0;
            pos_q  <= '0;
        end else if (adv) begin
            if (busy_q) begin
                pos_q <= pos_q + UW'(LANES);
                if (last) busy_q <= 1'b0;
            end else if (start) begin
                busy_q <= 1'b1;
                len_q  <= start_len;
                pos_q  <= UW'(LANES);
            end
        end
    end
endmodule

// File: rtl/dsa_alloc_top.sv
// Decode slot allocator top: serves two threads in alternate turns, packs up
// to LANES micro-ops per cycle into a registered group, diverts long
// instructions to the sequencer and locks both windows while it streams.
// Assumes upstream advances each window by take_* at the clock edge.
module dsa_alloc_top
    import dsa_pkg::*;
#(
    parameter int LANES = 4,
    parameter int UW    = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       in_cnt_a,
    input  logic [LANES*UW-1:0] in_len_a,
    input  logic [CW-1:0]       in_cnt_b,
    input  logic [LANES*UW-1:0] in_len_b,
    output logic [CW-1:0]       take_a,
    output logic [CW-1:0]       take_b,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                out_thr,
    output logic [LANES-1:0]    out_lane_vld,
    output logic [LANES*UW-1:0] out_lane_len,
    output logic [LANES*UW-1:0] out_lane_idx,
    output logic                out_from_seq
);
    thr_e                cur;
    logic                adv, dec_en, start, use_seq, hold_turn;
    logic                seq_busy, seq_last, long_go;
    logic [CW-1:0]       win_cnt, alloc_take;
    logic [LANES*UW-1:0] win_len;
    logic [LANES-1:0]    a_vld, s_vld, nxt_vld;
    logic [LANES*UW-1:0] a_len, a_idx, s_len, s_idx, nxt_len, nxt_idx;

    dsa_thread_turn #(.LANES(LANES), .UW(UW)) u_turn (
        .clk(clk), .rst_n(rst_n), .adv(adv), .hold_turn(hold_turn),
        .cnt_a(in_cnt_a), .len_a(in_len_a), .cnt_b(in_cnt_b), .len_b(in_len_b),
        .cur(cur), .win_cnt(win_cnt), .win_len(win_len)
    );

    dsa_slot_alloc #(.LANES(LANES), .UW(UW)) u_alloc (
        .win_cnt(win_cnt), .win_len(win_len), .take(alloc_take), .long_go(long_go),
        .lane_vld(a_vld), .lane_len(a_len), .lane_idx(a_idx)
    );

    dsa_ucode_seq #(.LANES(LANES), .UW(UW)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(adv), .start(start),
        .start_len(win_len[UW-1:0]), .busy(seq_busy), .last(seq_last),
        .lane_vld(s_vld), .lane_len(s_len), .lane_idx(s_idx)
    );

    // Stage control: advance, decoder lockout and turn hold.
    always_comb begin
        adv       = !out_valid || out_ready;
        dec_en    = !seq_busy;
        start     = dec_en && long_go;
        use_seq   = seq_busy || start;
        hold_turn = start || (seq_busy && !seq_last);
        take_a    = (adv && dec_en && cur == THR_A) ? alloc_take : '0;
        take_b    = (adv && dec_en && cur == THR_B) ? alloc_take : '0;
        nxt_vld   = use_seq ? s_vld : a_vld;
        nxt_len   = use_seq ? s_len : a_len;
        nxt_idx   = use_seq ? s_idx : a_idx;
    end

    // Output group register, held while the queue below is not ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_thr      <= 1'b0;
            out_lane_vld <= '0;
            out_lane_len <= '0;
            out_lane_idx <= '0;
            out_from_seq <= 1'b0;
        end else if (adv) begin
            out_valid    <= |nxt_vld;
            out_thr      <= cur;
            out_lane_vld <= nxt_vld;
            out_lane_len <= nxt_len;
            out_lane_idx <= nxt_idx;
            out_from_seq <= use_seq;
        end
    end
endmodule

// File: rtl/dsa_alloc_chk.sv
// Property checker for dsa_alloc_top, attached by bind below.
module dsa_alloc_chk #(
    parameter int LANES = 4,
    parameter int UW    = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CW-1:0]       take_a,
    input logic [CW-1:0]       take_b,
    input logic                out_ready,
    input logic                out_valid,
    input logic                out_thr,
    input logic [LANES-1:0]    out_lane_vld,
    input logic [LANES*UW-1:0] out_lane_len,
    input logic [LANES*UW-1:0] out_lane_idx,
    input logic                out_from_seq,
    input logic                seq_busy
);
    AST_SEQ_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (take_a == '0 && take_b == '0)); // R6

    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (take_a == '0 && take_b == '0)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_thr) &&
        $stable(out_lane_vld) && $stable(out_lane_len) &&
        $stable(out_lane_idx) && $stable(out_from_seq))); // R8

    AST_ONE_THREAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_a != '0 && take_b != '0)); // R7

    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lane_vld != '0 &&
        (out_lane_vld & (out_lane_vld + 1'b1)) == '0)); // R10

    for (genvar j = 1; j < LANES; j++) begin : g_narrow
        AST_NARROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_from_seq && out_lane_vld[j] &&
             out_lane_len[j*UW +: UW] != UW'(1))
            |-> (out_lane_idx[j*UW +: UW] == UW'(j))); // R3
    end
endmodule

bind dsa_alloc_top dsa_alloc_chk #(.LANES(LANES), .UW(UW)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_a(take_a), .take_b(take_b),
    .out_ready(out_ready), .out_valid(out_valid), .out_thr(out_thr),
    .out_lane_vld(out_lane_vld), .out_lane_len(out_lane_len),
    .out_lane_idx(out_lane_idx), .out_from_seq(out_from_seq),
    .seq_busy(seq_busy)
);

// File: tb/sim_dsa_alloc_top.sv
module sim_dsa_alloc_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int UW    = 4;
    localparam int CW    = 3;
    localparam int QN    = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] in_cnt_a = '0, in_cnt_b = '0, take_a, take_b;
    logic [LANES*UW-1:0] in_len_a = '0, in_len_b = '0, out_lane_len, out_lane_idx;
    logic out_ready = 1'b0, out_valid, out_thr, out_from_seq;
    logic [LANES-1:0] out_lane_vld;

    int qa[QN], qb[QN];
    int ha, hb, n_run, n_fail;
    int ei[2], eu[2];
    bit hold_pend;
    logic [LANES-1:0] sv_vld;
    logic [LANES*UW-1:0] sv_len, sv_idx;
    logic sv_thr, sv_seq;
    int ta, tb;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsa_alloc_top #(.LANES(LANES), .UW(UW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_cnt_a(in_cnt_a), .in_len_a(in_len_a),
        .in_cnt_b(in_cnt_b), .in_len_b(in_len_b), .take_a(take_a), .take_b(take_b),
        .out_ready(out_ready), .out_valid(out_valid), .out_thr(out_thr),
        .out_lane_vld(out_lane_vld), .out_lane_len(out_lane_len),
        .out_lane_idx(out_lane_idx), .out_from_seq(out_from_seq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int qlen(input int t, input int k);
        return (t == 0) ? qa[k] : qb[k];
    endfunction

    // Greedy in-order take count from the requirements (R2, R3, R4, R5).
    function automatic int exp_take(input int t, input int h, input int cnt);
        int k, room;
        if (cnt == 0) return 0;
        if (qlen(t, h) > LANES) return 1;
        k = 1;
        room = LANES - qlen(t, h);
        for (int i = 1; i < cnt; i++) begin
            if (qlen(t, h + i) == 1 && room > 0) begin
                k++;
                room--;
            end else break;
        end
        return k;
    endfunction

    // Per-thread micro-op scoreboard for an accepted group (R10, R2, R5).
    task automatic score();
        int t, L;
        if (!(out_valid && out_ready)) return;
        t = int'(out_thr);
        for (int j = 0; j < LANES; j++) begin
            if (out_lane_vld[j]) begin
                if (ei[t] >= QN) begin
                    check(1'b0, "R10 extra micro-op", ei[t], QN - 1);
                end else begin
                    L = qlen(t, ei[t]);
                    check(int'(out_lane_len[j*UW +: UW]) == L, "R10 lane length order",
                          int'(out_lane_len[j*UW +: UW]), L);
                    check(int'(out_lane_idx[j*UW +: UW]) == eu[t], "R10 lane index order",
                          int'(out_lane_idx[j*UW +: UW]), eu[t]);
                    check(out_from_seq == (L > LANES), "R5 sequencer routing",
                          int'(out_from_seq), int'(L > LANES));
                    eu[t]++;
                    if (eu[t] == L) begin
                        ei[t]++;
                        eu[t] = 0;
                    end
                end
            end
        end
    endtask

    // One cycle: drive windows just after a falling edge, check, then wait.
    task automatic step(input int lim_a, input int lim_b, input bit rdy);
        int ca, cb;
        out_ready = rdy;
        ca = (QN - ha < lim_a) ? QN - ha : lim_a;
        cb = (QN - hb < lim_b) ? QN - hb : lim_b;
        in_cnt_a = CW'(ca);
        in_cnt_b = CW'(cb);
        in_len_a = '0;
        in_len_b = '0;
        for (int i = 0; i < ca; i++) in_len_a[i*UW +: UW] = UW'(qa[ha + i]);
        for (int i = 0; i < cb; i++) in_len_b[i*UW +: UW] = UW'(qb[hb + i]);
        #1;
        if (hold_pend) begin
            check(out_valid && out_lane_vld == sv_vld && out_lane_len == sv_len &&
                  out_lane_idx == sv_idx && out_thr == sv_thr && out_from_seq == sv_seq,
                  "R8 group held", int'(out_lane_vld), int'(sv_vld));
        end
        ta = int'(take_a);
        tb = int'(take_b);
        check(!(ta != 0 && tb != 0), "R7 single thread served", tb, 0);
        if (ta != 0) check(ta == exp_take(0, ha, ca), "R3 R4 take count A", ta, exp_take(0, ha, ca));
        if (tb != 0) check(tb == exp_take(1, hb, cb), "R3 R4 take count B", tb, exp_take(1, hb, cb));
        if (out_valid && !rdy) begin
            check(ta == 0 && tb == 0, "R8 no take on stall", ta + tb, 0);
            hold_pend = 1'b1;
            sv_vld = out_lane_vld; sv_len = out_lane_len; sv_idx = out_lane_idx;
            sv_thr = out_thr; sv_seq = out_from_seq;
        end else begin
            hold_pend = 1'b0;
        end
        score();
        ha += ta;
        hb += tb;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int s, r;
        s = $urandom(20240601);
        for (int k = 0; k < QN; k++) begin
            r = $urandom % 20;
            qa[k] = (r < 10) ? 1 : (r < 17) ? 2 + $urandom % 3 : 5 + $urandom % 8;
            r = $urandom % 20;
            qb[k] = (r < 10) ? 1 : (r < 17) ? 2 + $urandom % 3 : 5 + $urandom % 8;
        end
        qa[0] = 1; qa[1] = 1; qa[2] = 1; qa[3] = 1;
        qa[4] = 3; qa[5] = 1; qa[6] = 1; qa[7] = 10;
        qb[0] = 1; qb[1] = 2; qb[2] = 1; qb[3] = 1; qb[4] = 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
        check(take_a == 0 && take_b == 0, "R1 reset takes", int'(take_a) + int'(take_b), 0);

        // S1: thread A first, four singles fill every slot.
        step(4, 4, 1'b1);
        check(ta == 4 && tb == 0, "R1 R7 A served first", ta, 4);
        check(out_valid && out_lane_vld == 4'b1111 && out_thr == 1'b0,
              "R3 four singles", int'(out_lane_vld), 15);
        // S2: thread B window empty.
        step(4, 0, 1'b1);
        check(ta == 0 && tb == 0, "R9 empty turn takes nothing", ta + tb, 0);
        check(!out_valid, "R9 no group for empty turn", int'(out_valid), 0);
        // S3: A head of 3 leaves room for one single.
        step(4, 4, 1'b1);
        check(ta == 2, "R3 narrow slots shrink", ta, 2);
        check(out_lane_vld == 4'b1111 && out_lane_len[UW-1:0] == 3 &&
              out_lane_idx[2*UW +: UW] == 2 && out_lane_len[3*UW +: UW] == 1,
              "R2 wide slot lanes", int'(out_lane_len[UW-1:0]), 3);
        // S4: B single then a double, the double waits.
        step(4, 4, 1'b1);
        check(tb == 1, "R4 double waits for head", tb, 1);
        // S5: A single then a long one, the long one waits.
        step(4, 4, 1'b1);
        check(ta == 1, "R4 long waits for head", ta, 1);
        // S6: B double at head plus two singles.
        step(4, 4, 1'b1);
        check(tb == 3, "R2 R3 double head fill", tb, 3);
        // S7: A head of 10 goes to the sequencer.
        step(4, 4, 1'b1);
        check(ta == 1, "R5 long taken alone", ta, 1);
        check(out_from_seq && out_lane_vld == 4'b1111 && out_lane_idx[3*UW +: UW] == 3,
              "R5 first chunk", int'(out_lane_vld), 15);
        // S8, S9: decoders locked out.
        step(4, 4, 1'b1);
        check(ta == 0 && tb == 0, "R6 lockout cycle 1", ta + tb, 0);
        step(4, 4, 1'b1);
        check(ta == 0 && tb == 0, "R6 lockout cycle 2", ta + tb, 0);
        check(out_from_seq && out_lane_vld == 4'b0011 && out_lane_idx[UW-1:0] == 8 &&
              out_thr == 1'b0, "R5 remainder chunk", int'(out_lane_vld), 3);
        // S10: B served after the run.
        step(4, 4, 1'b1);
        check(tb != 0 && ta == 0, "R7 other thread after sequencer", tb, 1);
        // S11, S12: stall holds the group.
        step(4, 4, 1'b0);
        step(4, 4, 1'b0);

        for (int n = 0; n < 40000; n++) begin
            if (ha >= QN && hb >= QN && ei[0] >= QN && ei[1] >= QN) break;
            step($urandom % 5, $urandom % 5, ($urandom % 4) != 0);
        end
        check(ei[0] == QN, "R10 all thread A micro-ops delivered", ei[0], QN);
        check(ei[1] == QN, "R10 all thread B micro-ops delivered", ei[1], QN);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule